// File: doc/BRIEF.md
# Table-Free Mesh Route Selector

This block decides, for one switch of a two-dimensional mesh interconnect, which output ports a packet may take next toward its destination. It needs no routing table. It compares the switch's own row and column with the destination's row and column, then filters the candidate directions through a small set of per-switch configuration bits. Those bits describe three things: which turns the deadlock-avoidance scheme allows at the next switch, which neighbours are physically reachable, and which turns at the adjacent switch are broken.

The route decision is purely combinational from the coordinates and the stored configuration. A global controller loads the configuration through a narrow write port. The block reports three things:

- a mask of permissible minimal output ports;
- a flag for packets that have arrived;
- an escape request, which names a configured non-minimal port when every minimal port has been ruled out.

Top module: `mesh_route_calc`

## Requirements
- R1: Output mask bit order is N=bit0, E=bit1, S=bit2, W=bit3. North means a smaller row index and east means a larger column index.
- R2: For a destination straight along one axis, that port is offered when the destination is one hop away. Farther away, it is offered only if the port's straight-on permission bit is 1.
- R3: For a destination diagonally adjacent (both offsets equal to 1), each of the two candidate ports is gated by its broken-turn bit alone. The permission bit for that turn has no effect.
- R4: For any other diagonal destination, each candidate port is gated by its turn permission bit alone. The broken-turn bit has no effect.
- R5: A port whose reachability bit is 0 never appears in the mask.
- R6: Only directions that reduce the distance appear, so at most two mask bits are set.
- R7: When the destination equals the current coordinates, `arrived` is 1, the mask is 0 and no escape is requested.
- R8: When the mask is 0 and the packet has not arrived, `escape_req` is 1 and `escape_port` carries the configured escape direction (00=N, 01=E, 10=S, 11=W). Otherwise `escape_req` is 0.
- R9: A write with `cfg_sel` selects the target register, and the new value governs routing from the next clock cycle:
  - `cfg_sel`=0 writes the permissions. `cfg_wdata[3p+0]` is straight-on, `[3p+1]` is the first turn and `[3p+2]` is the second turn of port p (N=0, E=1, S=2, W=3). The first/second turns are E/W for N and S, and N/S for E and W.
  - `cfg_sel`=1 writes reachability into bits [3:0], in port order.
  - `cfg_sel`=2 writes the broken-turn bits. `[2p+0]` is the first turn and `[2p+1]` is the second turn of port p.
  - `cfg_sel`=3 writes the escape direction into bits [1:0].
  - Reset clears every configuration bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 12 | Configuration write data |
| cur_row | input | ROW_W | Row of this switch |
| cur_col | input | COL_W | Column of this switch |
| dst_row | input | ROW_W | Destination row |
| dst_col | input | COL_W | Destination column |
| port_mask | output | 4 | Permitted minimal output ports |
| arrived | output | 1 | Destination is this switch |
| escape_req | output | 1 | No minimal port survives; use the escape port |
| escape_port | output | 2 | Configured escape direction |

## Verification
The bench targets destinations exactly one hop away on the diagonal, with the permission and broken-turn bits set opposite to each other. A design that swapped the two would route into a dead link next door, or would refuse long paths that are legal. Straight destinations one hop away are tried with the straight-on permission cleared; a design that gated them anyway would strand packets one link from home. Destinations equal to the switch, and configurations that leave every port unreachable, check that `arrived` suppresses the escape and that an empty mask raises it. A wrong split between the two cases would either bounce delivered packets or drop stranded ones.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    localparam int NPORT    = 4;
    localparam int PERM_W   = 3 * NPORT;
    localparam int TURN_W   = 2 * NPORT;
    localparam int CFG_DW   = PERM_W;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        CFG_PERM = 2'd0,
        CFG_CONN = 2'd1,
        CFG_TURN = 2'd2,
        CFG_ESC  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [PERM_W-1:0] perm;
        logic [TURN_W-1:0] turn_ok;
        logic [NPORT-1:0]  conn;
        logic [1:0]        escape;
    } route_cfg_t;

endpackage

// File: rtl/mrc_cfg_regs.sv
module mrc_cfg_regs
    import mrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [CFG_DW-1:0] wdata,
    output route_cfg_t        cfg
);

    route_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel)
                CFG_PERM: cfg_d.perm    = wdata[PERM_W-1:0];
                CFG_CONN: cfg_d.conn    = wdata[NPORT-1:0];
                CFG_TURN: cfg_d.turn_ok = wdata[TURN_W-1:0];
                default:  cfg_d.escape  = wdata[1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/mrc_compare.sv
module mrc_compare
    import mrc_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic [ROW_W-1:0] cur_row,
    input  logic [COL_W-1:0] cur_col,
    input  logic [ROW_W-1:0] dst_row,
    input  logic [COL_W-1:0] dst_col,
    output logic [NPORT-1:0] toward,
    output logic [NPORT-1:0] hop,
    output logic             here
);

    logic [ROW_W-1:0] up_dist, down_dist;
    logic [COL_W-1:0] right_dist, left_dist;

    always_comb begin
        up_dist    = cur_row - dst_row;
        down_dist  = dst_row - cur_row;
        right_dist = dst_col - cur_col;
        left_dist  = cur_col - dst_col;

        toward[DIR_N] = dst_row < cur_row;
        toward[DIR_S] = dst_row > cur_row;
        toward[DIR_E] = dst_col > cur_col;
        toward[DIR_W] = dst_col < cur_col;

        hop[DIR_N] = toward[DIR_N] && (up_dist    == ROW_W'(1));
        hop[DIR_S] = toward[DIR_S] && (down_dist  == ROW_W'(1));
        hop[DIR_E] = toward[DIR_E] && (right_dist == COL_W'(1));
        hop[DIR_W] = toward[DIR_W] && (left_dist  == COL_W'(1));

        here = (dst_row == cur_row) && (dst_col == cur_col);
    end

endmodule

// File: rtl/mrc_port_gate.sv
module mrc_port_gate
    import mrc_pkg::*;
#(
    parameter int P = 0
) (
    input  logic [NPORT-1:0] toward,
    input  logic [NPORT-1:0] hop,
    input  logic             reach,
    input  logic [2:0]       perm,
    input  logic [1:0]       turn_ok,
    output logic             pick
);

    // ports 0 and 2 turn toward E/W, ports 1 and 3 toward N/S
    localparam int TA = (P % 2 == 0) ? 1 : 0;
    localparam int TB = (P % 2 == 0) ? 3 : 2;

    logic straight, turn_a, turn_b;

    always_comb begin
        straight = toward[P] && !toward[TA] && !toward[TB]
                   && (hop[P] || perm[0]);
        turn_a   = toward[P] && toward[TA]
                   && ((hop[P] && hop[TA]) ? turn_ok[0] : perm[1]);
        turn_b   = toward[P] && toward[TB]
                   && ((hop[P] && hop[TB]) ? turn_ok[1] : perm[2]);
        pick     = reach && (straight || turn_a || turn_b);
    end

endmodule

// File: rtl/mesh_route_calc.sv
module mesh_route_calc
    import mrc_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [11:0]      cfg_wdata,
    input  logic [ROW_W-1:0] cur_row,
    input  logic [COL_W-1:0] cur_col,
    input  logic [ROW_W-1:0] dst_row,
    input  logic [COL_W-1:0] dst_col,
    output logic [3:0]       port_mask,
    output logic             arrived,
    output logic             escape_req,
    output logic [1:0]       escape_port
);

    route_cfg_t       cfg_cur;
    logic [NPORT-1:0] toward, hop, picks;
    logic             here;

    mrc_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg_cur)
    );

    mrc_compare #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cmp (
        .cur_row (cur_row),
        .cur_col (cur_col),
        .dst_row (dst_row),
        .dst_col (dst_col),
        .toward  (toward),
        .hop     (hop),
        .here    (here)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mrc_port_gate #(.P(p)) u_gate (
            .toward  (toward),
            .hop     (hop),
            .reach   (cfg_cur.conn[p]),
            .perm    (cfg_cur.perm[3*p +: 3]),
            .turn_ok (cfg_cur.turn_ok[2*p +: 2]),
            .pick    (picks[p])
        );
    end

    always_comb begin
        port_mask   = picks;
        arrived     = here;
        escape_req  = !here && (picks == '0);
        escape_port = cfg_cur.escape;
    end

endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_sel,
    input logic [3:0]       conn_wdata,
    input logic [3:0]       conn_q,
    input logic [ROW_W-1:0] cur_row,
    input logic [COL_W-1:0] cur_col,
    input logic [ROW_W-1:0] dst_row,
    input logic [COL_W-1:0] dst_col,
    input logic [3:0]       port_mask,
    input logic             arrived,
    input logic             escape_req
);

    AST_UNREACHABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (port_mask & ~conn_q) == 4'b0000);                                  // R5
    AST_NORTH_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        port_mask[0] |-> (dst_row < cur_row));                              // R1
    AST_EAST_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        port_mask[1] |-> (dst_col > cur_col));                              // R6
    AST_SOUTH_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        port_mask[2] |-> (dst_row > cur_row));                              // R6
    AST_WEST_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        port_mask[3] |-> (dst_col < cur_col));                              // R6
    AST_TWO_PORTS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(port_mask) <= 2);                                        // R6
    AST_ARRIVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        arrived |-> (port_mask == 4'b0000 && !escape_req));                 // R7
    AST_ESCAPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        escape_req |-> (port_mask == 4'b0000 && !arrived));                 // R8
    AST_ESCAPE_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (port_mask == 4'b0000 && !arrived) |-> escape_req);                 // R8
    AST_CONN_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd1) |=> (conn_q == $past(conn_wdata)));     // R9

endmodule

bind mesh_route_calc mrc_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .conn_wdata (cfg_wdata[3:0]),
    .conn_q     (cfg_cur.conn),
    .cur_row    (cur_row),
    .cur_col    (cur_col),
    .dst_row    (dst_row),
    .dst_col    (dst_col),
    .port_mask  (port_mask),
    .arrived    (arrived),
    .escape_req (escape_req)
);

// File: tb/mesh_route_calc_test.sv
module mesh_route_calc_test;

    localparam int RW = 3;
    localparam int CW = 3;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cfg_we = 0;
    logic [1:0]    cfg_sel = 0;
    logic [11:0]   cfg_wdata = 0;
    logic [RW-1:0] cur_row = 0, dst_row = 0;
    logic [CW-1:0] cur_col = 0, dst_col = 0;
    logic [3:0]    port_mask;
    logic          arrived, escape_req;
    logic [1:0]    escape_port;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    logic [11:0] perm_m = 0;
    logic [7:0]  turn_m = 0;
    logic [3:0]  conn_m = 0;
    logic [1:0]  esc_m  = 0;

    always #5 clk = ~clk;

    mesh_route_calc #(.ROW_W(RW), .COL_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cur_row(cur_row), .cur_col(cur_col),
        .dst_row(dst_row), .dst_col(dst_col), .port_mask(port_mask),
        .arrived(arrived), .escape_req(escape_req), .escape_port(escape_port)
    );

    function automatic logic [3:0] exp_mask(int cr, int cc, int dr, int dc);
        int dy = dr - cr;
        int dx = dc - cc;
        logic [3:0] m = 4'b0000;
        if (dy < 0) begin
            if (dx == 0)     m[0] = (dy == -1) || perm_m[0];
            else if (dx > 0) m[0] = (dy == -1 && dx == 1)  ? turn_m[0] : perm_m[1];
            else             m[0] = (dy == -1 && dx == -1) ? turn_m[1] : perm_m[2];
        end
        if (dx > 0) begin
            if (dy == 0)     m[1] = (dx == 1) || perm_m[3];
            else if (dy < 0) m[1] = (dx == 1 && dy == -1) ? turn_m[2] : perm_m[4];
            else             m[1] = (dx == 1 && dy == 1)  ? turn_m[3] : perm_m[5];
        end
        if (dy > 0) begin
            if (dx == 0)     m[2] = (dy == 1) || perm_m[6];
            else if (dx > 0) m[2] = (dy == 1 && dx == 1)  ? turn_m[4] : perm_m[7];
            else             m[2] = (dy == 1 && dx == -1) ? turn_m[5] : perm_m[8];
        end
        if (dx < 0) begin
            if (dy == 0)     m[3] = (dx == -1) || perm_m[9];
            else if (dy < 0) m[3] = (dx == -1 && dy == -1) ? turn_m[6] : perm_m[10];
            else             m[3] = (dx == -1 && dy == 1)  ? turn_m[7] : perm_m[11];
        end
        return m & conn_m;
    endfunction

    task automatic write_cfg(input logic [1:0] sel, input logic [11:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 0;
        case (sel)
            2'd0: perm_m = data;
            2'd1: conn_m = data[3:0];
            2'd2: turn_m = data[7:0];
            default: esc_m = data[1:0];
        endcase
    endtask

    task automatic probe(input int cr, input int cc, input int dr, input int dc,
                         input string req);
        logic [3:0] em;
        logic       ea, ee;
        cur_row = RW'(cr); cur_col = CW'(cc);
        dst_row = RW'(dr); dst_col = CW'(dc);
        #1;
        em = exp_mask(cr, cc, dr, dc);
        ea = (cr == dr) && (cc == dc);
        ee = !ea && (em == 4'b0000);
        n_cmp++;
        if (port_mask !== em || arrived !== ea || escape_req !== ee ||
            (ee && escape_port !== esc_m)) begin
            n_bad++;
            $display("FAIL %s: (%0d,%0d)->(%0d,%0d) got mask=%b arr=%b esc=%b dir=%0d exp mask=%b arr=%b esc=%b dir=%0d",
                     req, cr, cc, dr, dc, port_mask, arrived, escape_req, escape_port,
                     em, ea, ee, esc_m);
        end
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog: got cycles=%0d exp <=100000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset: all config zero -> no port, escape N (R9, R8)
        probe(3, 3, 1, 3, "R9 reset state");
        probe(2, 2, 2, 2, "R7 arrived after reset");

        write_cfg(2'd1, 12'h00F);
        // straight one hop with permission off (R2)
        probe(4, 4, 3, 4, "R2 straight north one hop");
        probe(4, 4, 4, 5, "R1 straight east one hop");
        probe(4, 4, 1, 4, "R2 straight far north, no permission");
        write_cfg(2'd0, 12'h249); // all straight-on bits set
        probe(4, 4, 1, 4, "R2 straight far north, permitted");
        probe(4, 4, 4, 0, "R1 straight far west, permitted");

        // diagonal one hop: turn bits rule, permission ignored (R3)
        write_cfg(2'd0, 12'hFFF);
        write_cfg(2'd2, 12'h000);
        probe(4, 4, 3, 5, "R3 NE adjacent, broken turns");
        probe(4, 4, 5, 3, "R3 SW adjacent, broken turns");
        write_cfg(2'd0, 12'h000);
        write_cfg(2'd2, 12'h0FF);
        probe(4, 4, 3, 5, "R3 NE adjacent, healthy turns");
        // far diagonal: permissions rule, turn bits ignored (R4)
        probe(4, 4, 1, 7, "R4 NE far, no permission");
        write_cfg(2'd0, 12'hFFF);
        write_cfg(2'd2, 12'h000);
        probe(4, 4, 1, 7, "R4 NE far, permitted");
        probe(4, 4, 6, 0, "R4 SW far, permitted");

        // unreachable ports (R5) and escape direction (R8)
        write_cfg(2'd1, 12'h005);
        write_cfg(2'd3, 12'h002);
        probe(4, 4, 4, 6, "R5 east unreachable");
        probe(4, 4, 2, 6, "R5 NE only north reachable");
        write_cfg(2'd3, 12'h003);
        probe(4, 4, 4, 1, "R8 escape west code");
        probe(0, 0, 0, 0, "R7 arrived corner");

        for (int i = 0; i < 400; i++) begin
            write_cfg(2'($urandom_range(0, 3)), 12'($urandom));
            for (int k = 0; k < 4; k++)
                probe($urandom_range(0, 7), $urandom_range(0, 7),
                      $urandom_range(0, 7), $urandom_range(0, 7), "R6 random route");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule